// File: doc/BRIEF.md
# Quad Quasi-Bidirectional GPIO Port Controller

This block controls several general-purpose I/O ports, each a byte wide, through a small synchronous register interface. Each port has a data register and runs in one of three drive modes: pulled-up input, open-drain output, or push-pull output. Writing 1 to a data bit in input mode releases the pin and turns on its pull-up. Writing 0 turns on the low-side sink. The pin-side outputs are enable signals: low sink, high source and pull-up. An external pad cell turns them into drive, and it returns the pad level on `pin_in`.

Pin levels pass through a two-stage synchronizer. A qualified edge on a pin whose interrupt enable bit is set is latched into a pending register. The single interrupt request is the OR of all pending bits. Software clears all pending bits by writing to a dedicated address. Each port has its own edge polarity. A port in push-pull mode raises no interrupts at all.

The bus is control traffic and carries no data stream, so it has no valid/ready handshake and never applies back-pressure. A write takes effect on the clock edge on which `bus_wr_en` is high. A read is captured on the edge on which `bus_rd_en` is high, and `bus_rd_data` holds that value until the next read.

Top module: `gpio_quad_ctrl`

## Requirements
- R1: After reset, every data bit is 1. Every pin then has its pull-up enabled, its sink off and its source off. The interrupt request is low and the configuration register reads 0x00.
- R2: Writing a byte to a port data address (0x0 to 0x3, one per port) sets that port's `pin_sink_en` to the inverse of the byte on the next cycle. In the pulled-up input modes, `pin_pull_en` then equals the byte.
- R3: A read of a port data address returns that port's synchronized pin levels. The value appears on `bus_rd_data` one cycle after the read strobe.
- R4: Interrupt enable registers (0x4 to 0x7, one per port) reset to zero, so edges on pins that are not enabled never raise the interrupt request.
- R5: When a port's mode code is 01 (pulled-up input, rising edge) and the pin's enable bit is set, a 0-to-1 pin change raises `irq` three clock edges after the change. A 1-to-0 change does not raise it.
- R6: With mode code 00 (pulled-up input, falling edge), a 1-to-0 change on an enabled pin raises `irq`, and a 0-to-1 change does not.
- R7: With mode code 11 (push-pull), each data bit drives either the source (1) or the sink (0), never the pull-up. The port raises no interrupt, whatever its enable bits hold.
- R8: With mode code 10 (open-drain), a data bit of 1 leaves sink, source and pull-up all off. Enabled pins of an open-drain port interrupt on falling edges.
- R9: Reads of the write-only enable addresses, of the clear address 0x9 and of unmapped addresses return 0x00.
- R10: A pending edge keeps `irq` high until a write to address 0x9. After that write, `irq` is low on the next cycle.
- R11: The configuration register at 0x8 holds two bits per port, with port p in bits [2p+1:2p]. It can be read back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address for reads and writes |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_data | input | PORT_W | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rd_data | output | PORT_W | Registered read data |
| pin_in | input | NUM_PORTS*PORT_W | Pad levels, port p in bits [p*PORT_W +: PORT_W] |
| pin_sink_en | output | NUM_PORTS*PORT_W | Low-side sink enable per pin |
| pin_src_en | output | NUM_PORTS*PORT_W | High-side source enable per pin |
| pin_pull_en | output | NUM_PORTS*PORT_W | Pull-up enable per pin |
| irq | output | 1 | Interrupt request, OR of pending edges |

## Verification
The bench builds the block with its defaults: four ports of eight pins, a four-bit address and two synchronizer stages. With these values all four mode codes can be set at once, one port per code, so the test shows that each port's polarity and push-pull masking act only on that port. The same build covers every register address, including the clear address and the unmapped space above it.

// File: rtl/gpio_quad_pkg.sv
package gpio_quad_pkg;
  typedef enum logic [1:0] {
    MODE_IN_FALL    = 2'b00,
    MODE_IN_RISE    = 2'b01,
    MODE_OPEN_DRAIN = 2'b10,
    MODE_PUSH_PULL  = 2'b11
  } port_mode_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '1;
        else        stage_q[s] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '1;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_drive_map.sv
module gpio_drive_map
  import gpio_quad_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  port_mode_e       mode,
  input  logic [WIDTH-1:0] data,
  output logic [WIDTH-1:0] sink_en,
  output logic [WIDTH-1:0] src_en,
  output logic [WIDTH-1:0] pull_en
);
  always_comb begin
    sink_en = ~data;
    src_en  = '0;
    pull_en = '0;
    unique case (mode)
      MODE_IN_FALL, MODE_IN_RISE: pull_en = data;
      MODE_OPEN_DRAIN:            pull_en = '0;
      MODE_PUSH_PULL:             src_en  = data;
      default:                    pull_en = data;
    endcase
  end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_quad_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned WIDTH     = 8,
  localparam int unsigned PINS     = NUM_PORTS * WIDTH,
  localparam int unsigned CFG_W    = 2 * NUM_PORTS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PINS-1:0]  pin_s,
  input  logic [CFG_W-1:0] cfg,
  input  logic [PINS-1:0]  ien,
  input  logic             clr,
  output logic             irq
);
  logic [PINS-1:0] prev_q;
  logic [PINS-1:0] pend_q;
  logic [PINS-1:0] hit;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [1:0]       code;
    logic [WIDTH-1:0] rise, fall, sel;
    assign code = cfg[2*p +: 2];
    assign rise = pin_s[p*WIDTH +: WIDTH] & ~prev_q[p*WIDTH +: WIDTH];
    assign fall = ~pin_s[p*WIDTH +: WIDTH] & prev_q[p*WIDTH +: WIDTH];
    assign sel  = code[0] ? rise : fall;
    assign hit[p*WIDTH +: WIDTH] =
      (code == MODE_PUSH_PULL) ? '0 : (sel & ien[p*WIDTH +: WIDTH]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '1;
      pend_q <= '0;
    end else begin
      prev_q <= pin_s;
      pend_q <= (clr ? '0 : pend_q) | hit;
    end
  end

  assign irq = |pend_q;
endmodule

// File: rtl/gpio_quad_ctrl.sv
module gpio_quad_ctrl
  import gpio_quad_pkg::*;
#(
  parameter int unsigned NUM_PORTS   = 4,
  parameter int unsigned PORT_W      = 8,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned PINS       = NUM_PORTS * PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [PORT_W-1:0] bus_wr_data,
  input  logic              bus_rd_en,
  output logic [PORT_W-1:0] bus_rd_data,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_sink_en,
  output logic [PINS-1:0]   pin_src_en,
  output logic [PINS-1:0]   pin_pull_en,
  output logic              irq
);
  localparam int unsigned CFG_W = 2 * NUM_PORTS;
  localparam logic [ADDR_W-1:0] IEN_BASE = ADDR_W'(NUM_PORTS);
  localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(2 * NUM_PORTS);
  localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(2 * NUM_PORTS + 1);

  logic [PINS-1:0]   data_q;
  logic [PINS-1:0]   ien_q;
  logic [CFG_W-1:0]  cfg_q;
  logic [PORT_W-1:0] rd_q;
  logic [PORT_W-1:0] rd_mux;
  logic [PINS-1:0]   pin_s;
  logic              clr_hit;

  gpio_pin_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (pin_s)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(p);
    localparam logic [ADDR_W-1:0] IEN_A  = ADDR_W'(NUM_PORTS + p);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q[p*PORT_W +: PORT_W] <= '1;
        ien_q[p*PORT_W +: PORT_W]  <= '0;
      end else if (bus_wr_en) begin
        if (bus_addr == DATA_A) data_q[p*PORT_W +: PORT_W] <= bus_wr_data;
        if (bus_addr == IEN_A)  ien_q[p*PORT_W +: PORT_W]  <= bus_wr_data;
      end
    end

    gpio_drive_map #(.WIDTH(PORT_W)) drv_i (
      .mode    (port_mode_e'(cfg_q[2*p +: 2])),
      .data    (data_q[p*PORT_W +: PORT_W]),
      .sink_en (pin_sink_en[p*PORT_W +: PORT_W]),
      .src_en  (pin_src_en[p*PORT_W +: PORT_W]),
      .pull_en (pin_pull_en[p*PORT_W +: PORT_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                cfg_q <= '0;
    else if (bus_wr_en && bus_addr == CFG_ADDR) cfg_q <= bus_wr_data[CFG_W-1:0];
  end

  assign clr_hit = bus_wr_en && (bus_addr == CLR_ADDR);

  gpio_edge_irq #(.NUM_PORTS(NUM_PORTS), .WIDTH(PORT_W)) edge_i (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_s (pin_s),
    .cfg   (cfg_q),
    .ien   (ien_q),
    .clr   (clr_hit),
    .irq   (irq)
  );

  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (bus_addr == ADDR_W'(p)) rd_mux = pin_s[p*PORT_W +: PORT_W];
    end
    if (bus_addr == CFG_ADDR) rd_mux = PORT_W'(cfg_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rd_q <= '0;
    else if (bus_rd_en) rd_q <= rd_mux;
  end

  assign bus_rd_data = rd_q;

  // IEN_BASE marks the start of the write-only range; reads there fall to zero.
  logic unused_base;
  assign unused_base = ^IEN_BASE;
endmodule

// File: rtl/gpio_quad_ctrl_chk.sv
module gpio_quad_ctrl_chk #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned PORT_W    = 8,
  parameter int unsigned ADDR_W    = 4,
  localparam int unsigned PINS     = NUM_PORTS * PORT_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr_en,
  input logic [PORT_W-1:0] bus_wr_data,
  input logic              bus_rd_en,
  input logic [PORT_W-1:0] bus_rd_data,
  input logic [PINS-1:0]   pin_sink_en,
  input logic [PINS-1:0]   pin_src_en,
  input logic [PINS-1:0]   pin_pull_en,
  input logic              irq
);
  localparam logic [ADDR_W-1:0] IEN_LO = ADDR_W'(NUM_PORTS);
  localparam logic [ADDR_W-1:0] CFG_A  = ADDR_W'(2 * NUM_PORTS);
  localparam logic [ADDR_W-1:0] CLR_A  = ADDR_W'(2 * NUM_PORTS + 1);

  assert_sink_pull_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_sink_en & pin_pull_en) == '0);

  assert_src_pull_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_src_en & pin_pull_en) == '0);

  assert_sink_src_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_src_en & pin_sink_en) == '0);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_wr
    assert_data_write_sink_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_en && bus_addr == ADDR_W'(p))
      |=> pin_sink_en[p*PORT_W +: PORT_W] == ~$past(bus_wr_data));
  end

  assert_wo_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && ((bus_addr >= IEN_LO && bus_addr < CFG_A) || bus_addr >= CLR_A))
    |=> bus_rd_data == '0);

  assert_irq_drop_on_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(bus_wr_en && bus_addr == CLR_A));
endmodule

bind gpio_quad_ctrl gpio_quad_ctrl_chk #(
  .NUM_PORTS (NUM_PORTS),
  .PORT_W    (PORT_W),
  .ADDR_W    (ADDR_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_wr_en   (bus_wr_en),
  .bus_wr_data (bus_wr_data),
  .bus_rd_en   (bus_rd_en),
  .bus_rd_data (bus_rd_data),
  .pin_sink_en (pin_sink_en),
  .pin_src_en  (pin_src_en),
  .pin_pull_en (pin_pull_en),
  .irq         (irq)
);

// File: tb/gpio_quad_ctrl_tb_top.sv
module gpio_quad_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int W  = 8;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr_en = 1'b0;
  logic [W-1:0]  bus_wr_data = '0;
  logic          bus_rd_en = 1'b0;
  logic [W-1:0]  bus_rd_data;
  logic [NP*W-1:0] pin_in = '1;
  logic [NP*W-1:0] pin_sink_en, pin_src_en, pin_pull_en;
  logic          irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_quad_ctrl #(.NUM_PORTS(NP), .PORT_W(W), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wr_data(bus_wr_data), .bus_rd_en(bus_rd_en), .bus_rd_data(bus_rd_data),
    .pin_in(pin_in), .pin_sink_en(pin_sink_en), .pin_src_en(pin_src_en),
    .pin_pull_en(pin_pull_en), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [W-1:0] d);
    bus_addr = a; bus_wr_data = d; bus_wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  // driver: pushes the expected read value, the monitor compares it
  task automatic rd(logic [AW-1:0] a, logic [W-1:0] exp, string req);
    exp_q.push_back(exp); tag_q.push_back(req);
    bus_addr = a; bus_rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_rd_en = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      bit fire;
      @(posedge clk);
      fire = bus_rd_en;
      @(negedge clk);
      if (fire) begin
        if (exp_q.size() == 0) check("SCOREBOARD", 32'd1, 32'd0);
        else check(tag_q.pop_front(), 32'(bus_rd_data), 32'(exp_q.pop_front()));
      end
    end
  end

  task automatic set_pin(int idx, logic v);
    pin_in[idx] = v;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    // R1 reset state
    check("R1 sink", 32'(pin_sink_en), 32'h0);
    check("R1 pull", 32'(pin_pull_en), 32'hFFFF_FFFF);
    check("R1 src", 32'(pin_src_en), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    rd(4'h8, 8'h00, "R1 R11 cfg reset");
    rd(4'h0, 8'hFF, "R3 port0 idle high");

    // R2 data write in input mode
    wr(4'h1, 8'hA5);
    check("R2 sink port1", 32'(pin_sink_en[15:8]), 32'h5A);
    check("R2 pull port1", 32'(pin_pull_en[15:8]), 32'hA5);
    check("R2 src port1", 32'(pin_src_en[15:8]), 32'h00);

    // R3 pin read through synchronizer
    pin_in[23:16] = 8'h3C;
    wait_cyc(4);
    rd(4'h2, 8'h3C, "R3 port2 read");
    pin_in[23:16] = 8'hFF;
    wait_cyc(4);

    // R4 edges with enables cleared
    set_pin(0, 1'b0); wait_cyc(5);
    check("R4 no irq when disabled", 32'(irq), 32'h0);
    set_pin(0, 1'b1); wait_cyc(5);

    // R5 rising polarity on port0
    wr(4'h8, 8'h01);
    wr(4'h4, 8'h01);
    set_pin(0, 1'b0); wait_cyc(5);
    check("R5 falling ignored", 32'(irq), 32'h0);
    set_pin(0, 1'b1);
    wait_cyc(2);
    check("R5 not yet", 32'(irq), 32'h0);
    wait_cyc(1);
    check("R5 rise raises irq", 32'(irq), 32'h1);
    wait_cyc(8);
    check("R10 pending holds", 32'(irq), 32'h1);
    wr(4'h9, 8'h00);
    check("R10 cleared", 32'(irq), 32'h0);

    // R6 falling polarity on port3
    wr(4'h7, 8'h80);
    set_pin(31, 1'b0); wait_cyc(3);
    check("R6 fall raises irq", 32'(irq), 32'h1);
    wr(4'h9, 8'h00);
    set_pin(31, 1'b1); wait_cyc(5);
    check("R6 rise ignored", 32'(irq), 32'h0);

    // R7 push-pull on port2
    wr(4'h8, 8'h31);
    wr(4'h2, 8'h0F);
    check("R7 src", 32'(pin_src_en[23:16]), 32'h0F);
    check("R7 sink", 32'(pin_sink_en[23:16]), 32'hF0);
    check("R7 pull", 32'(pin_pull_en[23:16]), 32'h00);
    wr(4'h6, 8'hFF);
    pin_in[23:16] = 8'h00; wait_cyc(5);
    pin_in[23:16] = 8'hFF; wait_cyc(5);
    check("R7 no irq in push-pull", 32'(irq), 32'h0);

    // R8 open-drain on port1 (data still 0xA5)
    wr(4'h8, 8'h39);
    check("R8 pull off", 32'(pin_pull_en[15:8]), 32'h00);
    check("R8 src off", 32'(pin_src_en[15:8]), 32'h00);
    check("R8 sink", 32'(pin_sink_en[15:8]), 32'h5A);
    wr(4'h5, 8'h02);
    set_pin(9, 1'b0); wait_cyc(3);
    check("R8 fall raises irq", 32'(irq), 32'h1);
    wr(4'h9, 8'h00);
    check("R8 R10 cleared", 32'(irq), 32'h0);
    set_pin(9, 1'b1); wait_cyc(4);

    // R9 and R11 readback
    rd(4'h4, 8'h00, "R9 ien0 reads zero");
    rd(4'h7, 8'h00, "R9 ien3 reads zero");
    rd(4'h9, 8'h00, "R9 clear addr reads zero");
    rd(4'hF, 8'h00, "R9 unmapped reads zero");
    rd(4'h8, 8'h39, "R11 cfg readback");
    rd(4'h2, 8'hFF, "R3 port2 high again");

    wait_cyc(2);
    check("SCOREBOARD drained", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule